// File: doc/BRIEF.md
# Vector Length Setting Unit

This block carries out the instruction that configures the vector length of a vector-extended scalar core. One instruction word comes in together with the value of the source register it names, the loop count register and the current vector-state register. The block decodes the word and works out the new maximum vector length (MVL) and the new vector length (VL). It produces the updated vector-state word, an optional write-back of VL to the destination register, and an optional 4-bit condition field.

VL can come from one of four places: the state register, an immediate with a built-in +1 bias, the source register or the count register. The RA and RT register numbers being zero or nonzero decide which one is used. Register or count values that do not fit in 7 bits saturate. A VL above MVL is clamped. Both events raise an overflow flag, and that flag reaches the summary-overflow bit of the condition field. The condition field describes VL, not the destination register.

All outputs are registered. A result appears one clock after the instruction is presented with its valid strobe.

Top module: `setvl_unit`

## Requirements
- R1: The state, write-back and condition write-enables rise only in the cycle after a cycle with valid_i high and a matching instruction. A match means primary opcode insn_i[31:26] equals PRI_OPC (default 22) and extended opcode insn_i[5:1] equals EXT_OPC (default 27). In every other case all three enables are low.
- R2: Instruction fields are RT=insn_i[25:21], RA=insn_i[20:16], immediate SVi=insn_i[15:9], set-max ms=insn_i[8], set-length vs=insn_i[7], vertical-first vf=insn_i[6] and Rc=insn_i[0]. The effective immediate is the low 7 bits of SVi+1, so SVi=127 yields 0. With ms=1 the new MVL is the effective immediate. With ms=0 it is the old MVL held in state_i[63:57].
- R3: With vs=0, VL starts from the old VL in state_i[56:50]. With vs=1 the source depends on the register numbers: RA≠0 selects the RA register value, RA=0 with RT=0 selects the effective immediate, and RA=0 with RT≠0 selects the count register.
- R4: When VL comes from the RA register or the count register and the 64-bit value is above 127 (unsigned), VL becomes 127 and the overflow flag is set. Otherwise VL is the low 7 bits of that value.
- R5: If the selected VL is greater than the new MVL, VL is replaced by MVL and the overflow flag is set.
- R6: The new state carries MVL in bits [63:57] and VL in bits [56:50]. When RT≠0, the destination index is RT and the write-back data is VL zero-extended to 64 bits. When RT=0 there is no write-back.
- R7: With ms=1, state bit [0] takes vf and the persist bit [1] is cleared. With ms=0 both bits keep their old values.
- R8: State bits [49:2] pass through from state_i unchanged.
- R9: With Rc=1 the condition field is written even when RT=0. The field is cr_o[3]=LT (always 0), cr_o[2]=GE (VL nonzero), cr_o[1]=EQ (VL zero) and cr_o[0]=SO (overflow). With Rc=0 there is no condition write.
- R10: During reset and in the first cycle after it, all write-enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction presented this cycle |
| insn_i | input | 32 | Instruction word |
| ra_val_i | input | 64 | Value of the register named by RA |
| ctr_i | input | 64 | Count register value |
| state_i | input | 64 | Current vector-state register |
| state_o | output | 64 | Updated vector-state register |
| state_we_o | output | 1 | Vector-state write-enable |
| rt_we_o | output | 1 | Destination write-back enable |
| rt_idx_o | output | 5 | Destination register number |
| rt_data_o | output | 64 | Destination write-back data |
| cr_we_o | output | 1 | Condition field write-enable |
| cr_o | output | 4 | Condition field {LT, GE, EQ, SO} |

## Verification
The bench covers each RA/RT combination that picks the VL source. A design that mixes these up returns the count where the immediate was intended, or the reverse. It uses register and count values just above and far above 127, where truncating instead of saturating would give a small bogus VL with no overflow. It shrinks MVL below the old VL with vs=0, which tests whether the clamp applies even when VL is not being set. It also uses SVi=127, where the immediate wraps to zero and EQ must be set. Further checks cover opcode mismatches, Rc=0, RT=0 with Rc=1, and the vf and persist bits under ms=0, where a careless design would write a condition field or disturb state bits it must leave alone.

// File: rtl/setvl_pkg.sv
package setvl_pkg;

    localparam int XLEN    = 64;
    localparam int LEN_W   = 7;
    localparam int IDX_W   = 5;
    localparam int CR_W    = 4;
    localparam int SPARE_W = XLEN - 2 * LEN_W - 2;
    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

    // Vector-state layout, most significant field first
    typedef struct packed {
        logic [LEN_W-1:0]   mvl;
        logic [LEN_W-1:0]   vl;
        logic [SPARE_W-1:0] spare;
        logic               persist;
        logic               vfirst;
    } vstate_t;

    typedef struct packed {
        vstate_t           state;
        logic              state_we;
        logic              rt_we;
        logic [IDX_W-1:0]  rt_idx;
        logic [XLEN-1:0]   rt_data;
        logic              cr_we;
        logic [CR_W-1:0]   cr;
    } unit_out_t;

endpackage

// File: rtl/setvl_decode.sv
module setvl_decode
    import setvl_pkg::*;
#(
    parameter logic [5:0] PRI_OPC = 6'd22,
    parameter logic [4:0] EXT_OPC = 5'd27
) (
    input  logic             valid_i,
    input  logic [31:0]      insn_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] rt_o,
    output logic [IDX_W-1:0] ra_o,
    output logic [LEN_W-1:0] imm_o,
    output logic             ms_o,
    output logic             vs_o,
    output logic             vf_o,
    output logic             rc_o
);
    always_comb begin
        hit_o = valid_i && (insn_i[31:26] == PRI_OPC) && (insn_i[5:1] == EXT_OPC);
        rt_o  = insn_i[25:21];
        ra_o  = insn_i[20:16];
        imm_o = insn_i[15:9] + LEN_W'(1);   // biased length, wraps at 7 bits
        ms_o  = insn_i[8];
        vs_o  = insn_i[7];
        vf_o  = insn_i[6];
        rc_o  = insn_i[0];
    end
endmodule

// File: rtl/setvl_len_select.sv
module setvl_len_select
    import setvl_pkg::*;
(
    input  logic             vs_i,
    input  logic             ra_zero_i,
    input  logic             rt_zero_i,
    input  logic [XLEN-1:0]  ra_val_i,
    input  logic [XLEN-1:0]  ctr_i,
    input  logic [LEN_W-1:0] imm_i,
    input  logic [LEN_W-1:0] old_vl_i,
    output logic [LEN_W-1:0] vl_o,
    output logic             sat_o
);
    logic [XLEN-1:0] reg_src;
    logic            use_reg;

    always_comb begin
        reg_src = ra_zero_i ? ctr_i : ra_val_i;
        use_reg = vs_i && !(ra_zero_i && rt_zero_i);
        sat_o   = 1'b0;
        vl_o    = old_vl_i;
        if (vs_i) begin
            if (!use_reg) begin
                vl_o = imm_i;
            end else if (reg_src > XLEN'(LEN_MAX)) begin
                vl_o  = LEN_MAX;
                sat_o = 1'b1;
            end else begin
                vl_o = reg_src[LEN_W-1:0];
            end
        end
    end
endmodule

// File: rtl/setvl_clamp.sv
module setvl_clamp
    import setvl_pkg::*;
(
    input  logic [LEN_W-1:0] vl_i,
    input  logic [LEN_W-1:0] mvl_i,
    output logic [LEN_W-1:0] vl_o,
    output logic             clip_o
);
    always_comb begin
        clip_o = vl_i > mvl_i;
        vl_o   = clip_o ? mvl_i : vl_i;
    end
endmodule

// File: rtl/setvl_unit.sv
module setvl_unit
    import setvl_pkg::*;
#(
    parameter logic [5:0] PRI_OPC = 6'd22,
    parameter logic [4:0] EXT_OPC = 5'd27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [31:0]      insn_i,
    input  logic [XLEN-1:0]  ra_val_i,
    input  logic [XLEN-1:0]  ctr_i,
    input  logic [XLEN-1:0]  state_i,
    output logic [XLEN-1:0]  state_o,
    output logic             state_we_o,
    output logic             rt_we_o,
    output logic [IDX_W-1:0] rt_idx_o,
    output logic [XLEN-1:0]  rt_data_o,
    output logic             cr_we_o,
    output logic [CR_W-1:0]  cr_o
);
    logic             hit;
    logic [IDX_W-1:0] rt_f, ra_f;
    logic [LEN_W-1:0] imm;
    logic             ms, vs, vf, rc;
    vstate_t          old_st;
    logic [LEN_W-1:0] mvl_new, vl_sel, vl_fin;
    logic             sat, clip, ovf;
    unit_out_t        out_d, out_q;

    assign old_st = vstate_t'(state_i);

    setvl_decode #(.PRI_OPC(PRI_OPC), .EXT_OPC(EXT_OPC)) u_dec (
        .valid_i(valid_i), .insn_i(insn_i), .hit_o(hit),
        .rt_o(rt_f), .ra_o(ra_f), .imm_o(imm),
        .ms_o(ms), .vs_o(vs), .vf_o(vf), .rc_o(rc)
    );

    assign mvl_new = ms ? imm : old_st.mvl;

    setvl_len_select u_sel (
        .vs_i(vs), .ra_zero_i(ra_f == '0), .rt_zero_i(rt_f == '0),
        .ra_val_i(ra_val_i), .ctr_i(ctr_i), .imm_i(imm),
        .old_vl_i(old_st.vl), .vl_o(vl_sel), .sat_o(sat)
    );

    setvl_clamp u_clamp (
        .vl_i(vl_sel), .mvl_i(mvl_new), .vl_o(vl_fin), .clip_o(clip)
    );

    assign ovf = sat | clip;

    always_comb begin
        out_d           = '0;
        out_d.state     = old_st;
        out_d.state.mvl = mvl_new;
        out_d.state.vl  = vl_fin;
        if (ms) begin
            out_d.state.vfirst  = vf;
            out_d.state.persist = 1'b0;
        end
        out_d.state_we = hit;
        out_d.rt_we    = hit && (rt_f != '0);
        out_d.rt_idx   = rt_f;
        out_d.rt_data  = XLEN'(vl_fin);
        out_d.cr_we    = hit && rc;
        out_d.cr       = {1'b0, vl_fin != '0, vl_fin == '0, ovf};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign state_o    = out_q.state;
    assign state_we_o = out_q.state_we;
    assign rt_we_o    = out_q.rt_we;
    assign rt_idx_o   = out_q.rt_idx;
    assign rt_data_o  = out_q.rt_data;
    assign cr_we_o    = out_q.cr_we;
    assign cr_o       = out_q.cr;
endmodule

// File: rtl/setvl_unit_chk.sv
module setvl_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_i,
    input logic        ms_i,
    input logic        vs_i,
    input logic [63:0] state_i,
    input logic [63:0] state_o,
    input logic        state_we_o,
    input logic        rt_we_o,
    input logic [4:0]  rt_idx_o,
    input logic [63:0] rt_data_o,
    input logic        cr_we_o,
    input logic [3:0]  cr_o
);
    // R1: any enable needs a valid strobe one cycle earlier
    a_r1_we_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (state_we_o || rt_we_o || cr_we_o) |-> $past(valid_i));
    // R1: write-back and condition writes only accompany a state write
    a_r1_we_bundle: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_we_o || cr_we_o) |-> state_we_o);
    // R2: MVL kept when ms clear
    a_r2_mvl_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_we_o && !$past(ms_i)) |-> state_o[63:57] == $past(state_i[63:57]));
    // R3: VL kept when neither field is set and no clamp can apply
    a_r3_vl_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_we_o && !$past(ms_i) && !$past(vs_i)
         && ($past(state_i[56:50]) <= $past(state_i[63:57])))
        |-> state_o[56:50] == $past(state_i[56:50]));
    // R5: VL never exceeds MVL after the update
    a_r5_vl_within_mvl: assert property (@(posedge clk) disable iff (!rst_n)
        state_we_o |-> state_o[56:50] <= state_o[63:57]);
    // R6: write-back data mirrors the stored VL
    a_r6_rt_data: assert property (@(posedge clk) disable iff (!rst_n)
        rt_we_o |-> (rt_data_o == {57'd0, state_o[56:50]}) && (rt_idx_o != 5'd0));
    // R7: mode bits kept when ms clear
    a_r7_mode_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_we_o && !$past(ms_i)) |-> state_o[1:0] == $past(state_i[1:0]));
    // R7: persist cleared when ms set
    a_r7_persist_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (state_we_o && $past(ms_i)) |-> state_o[1] == 1'b0);
    // R8: middle bits pass through
    a_r8_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        state_we_o |-> state_o[49:2] == $past(state_i[49:2]));
    // R9: exactly one of GE/EQ, LT clear, EQ agrees with VL
    a_r9_cr_shape: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we_o |-> (cr_o[3] == 1'b0) && $onehot(cr_o[2:1])
                    && (cr_o[1] == (state_o[56:50] == 7'd0)));
endmodule

bind setvl_unit setvl_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
    .ms_i(insn_i[8]), .vs_i(insn_i[7]),
    .state_i(state_i), .state_o(state_o), .state_we_o(state_we_o),
    .rt_we_o(rt_we_o), .rt_idx_o(rt_idx_o), .rt_data_o(rt_data_o),
    .cr_we_o(cr_we_o), .cr_o(cr_o)
);

// File: tb/tb_setvl_unit.sv
module tb_setvl_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic [63:0] ra_val_i = '0, ctr_i = '0, state_i = '0;
    logic [63:0] state_o, rt_data_o;
    logic        state_we_o, rt_we_o, cr_we_o;
    logic [4:0]  rt_idx_o;
    logic [3:0]  cr_o;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic        we;
        logic [63:0] st;
        logic        rt_we;
        logic [4:0]  rt_idx;
        logic [63:0] rt_data;
        logic        cr_we;
        logic [3:0]  cr;
        string       tag;
    } exp_t;

    exp_t q[$];

    setvl_unit dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i),
        .ra_val_i(ra_val_i), .ctr_i(ctr_i), .state_i(state_i),
        .state_o(state_o), .state_we_o(state_we_o), .rt_we_o(rt_we_o),
        .rt_idx_o(rt_idx_o), .rt_data_o(rt_data_o), .cr_we_o(cr_we_o), .cr_o(cr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] rt, input logic [4:0] ra,
            input logic [6:0] svi, input logic ms, input logic vs, input logic vf,
            input logic rc, input logic [5:0] po = 6'd22, input logic [4:0] xo = 5'd27);
        return {po, rt, ra, svi, ms, vs, vf, xo, rc};
    endfunction

    function automatic exp_t model(input logic v, input logic [31:0] i, input logic [63:0] ra,
            input logic [63:0] ctr, input logic [63:0] st, input string tag);
        exp_t e;
        logic [6:0] imm, mvl, vl;
        logic ovf;
        e.tag = tag;
        e.we = v && i[31:26] == 6'd22 && i[5:1] == 5'd27;
        imm = i[15:9] + 7'd1;
        mvl = i[8] ? imm : st[63:57];
        ovf = 1'b0;
        if (!i[7]) vl = st[56:50];
        else if (i[20:16] != 0) begin
            if (ra > 64'd127) begin vl = 7'd127; ovf = 1'b1; end else vl = ra[6:0];
        end else if (i[25:21] == 0) vl = imm;
        else begin
            if (ctr > 64'd127) begin vl = 7'd127; ovf = 1'b1; end else vl = ctr[6:0];
        end
        if (vl > mvl) begin vl = mvl; ovf = 1'b1; end
        e.st = st;
        e.st[63:57] = mvl;
        e.st[56:50] = vl;
        if (i[8]) begin e.st[0] = i[6]; e.st[1] = 1'b0; end
        e.rt_we = e.we && i[25:21] != 0;
        e.rt_idx = i[25:21];
        e.rt_data = {57'd0, vl};
        e.cr_we = e.we && i[0];
        e.cr = {1'b0, vl != 0, vl == 0, ovf};
        return e;
    endfunction

    task automatic drive(input string tag, input logic v, input logic [31:0] i,
            input logic [63:0] ra, input logic [63:0] ctr, input logic [63:0] st);
        @(negedge clk);
        valid_i = v; insn_i = i; ra_val_i = ra; ctr_i = ctr; state_i = st;
        q.push_back(model(v, i, ra, ctr, st, tag));
    endtask

    function automatic logic [63:0] mkst(input logic [6:0] mvl, input logic [6:0] vl,
            input logic [47:0] mid, input logic [1:0] lo);
        return {mvl, vl, mid, lo};
    endfunction

    // monitor: compares one result per driven cycle
    always @(posedge clk) begin
        #2;
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " state_we"}, 64'(state_we_o), 64'(e.we));
            chk({e.tag, " rt_we"}, 64'(rt_we_o), 64'(e.rt_we));
            chk({e.tag, " cr_we"}, 64'(cr_we_o), 64'(e.cr_we));
            if (e.we) chk({e.tag, " state"}, state_o, e.st);
            if (e.rt_we) begin
                chk({e.tag, " rt_idx"}, 64'(rt_idx_o), 64'(e.rt_idx));
                chk({e.tag, " rt_data"}, rt_data_o, e.rt_data);
            end
            if (e.cr_we) chk({e.tag, " cr"}, 64'(cr_o), 64'(e.cr));
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] x;
        repeat (3) @(negedge clk);
        // R10: enables low in reset
        chk("R10 reset state_we", 64'(state_we_o), 64'd0);
        chk("R10 reset rt_we", 64'(rt_we_o), 64'd0);
        chk("R10 reset cr_we", 64'(cr_we_o), 64'd0);
        rst_n = 1'b1;
        // R2 R5 R7: set MVL=8 with old VL=20 -> clamp, vf set, persist cleared
        drive("R2/R5/R7 mvl imm clamp", 1, mk(0, 0, 7'd7, 1, 0, 1, 1), 0, 0,
              mkst(7'd50, 7'd20, 48'h1234_5678_9abc, 2'b10));
        // R3: immediate VL=5 under MVL=10
        drive("R3 vl imm", 1, mk(0, 0, 7'd4, 0, 1, 0, 1), 64'd99, 64'd99,
              mkst(7'd10, 7'd3, 48'd0, 2'b11));
        // R4: RA value 200 saturates, then clamps to MVL=100
        drive("R4 ra saturate", 1, mk(0, 3, 7'd0, 0, 1, 0, 1), 64'd200, 64'd1,
              mkst(7'd100, 7'd0, 48'd0, 2'b00));
        // R4: RA value exactly 127, no overflow
        drive("R4 ra edge 127", 1, mk(7, 3, 7'd0, 0, 1, 0, 1), 64'd127, 64'd1,
              mkst(7'd127, 7'd0, 48'd0, 2'b00));
        // R3 R6: count source with RT=5, MVL=64
        drive("R3/R6 ctr source", 1, mk(5, 0, 7'd0, 0, 1, 0, 1), 64'd77, 64'd6,
              mkst(7'd64, 7'd9, 48'd0, 2'b01));
        // R4: huge count saturates
        drive("R4 ctr saturate", 1, mk(5, 0, 7'd0, 0, 1, 0, 1), 64'd3, 64'h100_0000_0000,
              mkst(7'd127, 7'd9, 48'd0, 2'b01));
        // R4: count 128 saturates
        drive("R4 ctr 128", 1, mk(9, 0, 7'd0, 0, 1, 0, 1), 64'd3, 64'd128,
              mkst(7'd127, 7'd9, 48'd0, 2'b01));
        // R1: wrong primary opcode, wrong extended opcode, no valid
        drive("R1 bad primary", 1, mk(5, 0, 7'd3, 1, 1, 0, 1, 6'd23), 0, 0, '0);
        drive("R1 bad extended", 1, mk(5, 0, 7'd3, 1, 1, 0, 1, 6'd22, 5'd26), 0, 0, '0);
        drive("R1 no valid", 0, mk(5, 0, 7'd3, 1, 1, 0, 1), 0, 0, '0);
        // R9 R6: read VL=0 into RT, EQ set
        drive("R9/R6 read zero vl", 1, mk(5, 0, 7'd0, 0, 0, 0, 1), 0, 0,
              mkst(7'd8, 7'd0, 48'hffff_0000_ffff, 2'b11));
        // R2 R9: SVi=127 wraps to MVL=0, VL clamped to 0
        drive("R2/R9 imm wrap", 1, mk(0, 0, 7'd127, 1, 1, 0, 1), 0, 0,
              mkst(7'd30, 7'd12, 48'd0, 2'b11));
        // R9: Rc=0 suppresses condition write
        drive("R9 rc clear", 1, mk(4, 2, 7'd0, 0, 1, 0, 0), 64'd300, 0,
              mkst(7'd16, 7'd1, 48'd0, 2'b00));
        // R8 R7: middle bits preserved, mode bits kept under ms=0
        drive("R8/R7 passthrough", 1, mk(0, 0, 7'd2, 0, 1, 1, 1), 0, 0,
              mkst(7'd16, 7'd1, 48'hdead_beef_cafe, 2'b11));
        // pseudo-random sweep covering every rule
        x = 64'h9e37_79b9_7f4a_7c15;
        for (int n = 0; n < 400; n++) begin
            logic [63:0] ra, ctr;
            x ^= x << 13; x ^= x >> 7; x ^= x << 17;
            ra  = x[3] ? {57'd0, x[12:6]} : x;
            ctr = x[4] ? {57'd0, x[19:13]} : {x[31:0], x[63:32]};
            drive("R1-sweep R2 R3 R4 R5 R6 R7 R8 R9",
                  x[40] | x[41], mk(x[5] ? x[24:20] : 5'd0, x[2] ? x[29:25] : 5'd0,
                  x[36:30], x[37], x[38], x[39], x[42], x[43] & x[44] ? 6'd21 : 6'd22),
                  ra, ctr, {x[22:0], x[63:23]});
        end
        drive("R1 idle", 0, '0, 0, 0, '0);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule